// File: doc/BRIEF.md
# Two-Slice 8-bit ALU with Processor Carry Flag

This block is an 8-bit arithmetic unit made of two identical 4-bit slices. Each slice has a mode line, four function-select lines and an active-low carry input. Both slices see the same mode and select values. The active-low carry output of the lower slice feeds the carry input of the upper slice directly. Around the pair sits a thin adapter with three jobs. It turns a processor-level operation code into a select code and a lower-slice carry input. It reads the final slice carry output. It turns that output into a processor carry flag, which it stores in a register.

The final slice carry output does not have the same meaning for every operation. On the additive group it goes low when the sum overflows. On the subtractive group it goes high when a borrow occurs. Increment and decrement also break the simple rule of comparing the carry in with the carry out. For these reasons the flag is decoded separately for each operation.

A configuration input selects one of two flag conventions:
- **Direct convention** (`inv_borrow` = 0): a set flag always means a carry or a borrow.
- **Inverted-borrow convention** (`inv_borrow` = 1): a set flag after a subtraction means that no borrow occurred.

The result is combinational. The flag changes on the clock edge, so a chain of add-with-carry or subtract-with-borrow operations can build wider arithmetic one byte per cycle.

Top module: `alu8_cascade`

## Requirements
- R1: The op code is 3 bits. Code 0 is ADD. `result` = (a+b) mod 256, and the new flag is 1 exactly when a+b > 255, in both conventions.
- R2: Code 1 is ADC. With the stored flag C, `result` = (a+b+C) mod 256, and the new flag is 1 exactly when a+b+C > 255.
- R3: Code 2 is SUB. `result` = (a−b) mod 256. The new flag is (a<b) when `inv_borrow`=0 and (a≥b) when `inv_borrow`=1.
- R4: Code 3 is SBB.
  - With `inv_borrow`=0: `result` = (a−b−C) mod 256, and the flag is set exactly when a−b−C < 0.
  - With `inv_borrow`=1: `result` = (a−b−1+C) mod 256, and the flag is cleared exactly when a−b−1+C < 0.
- R5: Code 4 is INC. `result` = (a+1) mod 256, and the new flag is (a==255), in both conventions.
- R6: Code 5 is DEC. `result` = (a−1) mod 256. The new flag is (a==0) when `inv_borrow`=0 and (a!=0) when `inv_borrow`=1.
- R7: Code 6 is DBL. `result` = (2a) mod 256, and the new flag is bit 7 of a.
- R8: Code 7 passes a to `result` and leaves the flag unchanged. When `op_valid` is low, the flag also keeps its value whatever the op code.
- R9: `rst` is synchronous and active high. It clears the flag at the next rising edge and takes priority over any operation.
- R10: `result` follows the inputs in the same cycle. The flag takes its new value at the rising edge that samples `op_valid` high. ADC and SBB use that stored value, so ADD then ADC, or SUB then SBB, give a correct 16-bit sum or difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the carry flag |
| op_valid | input | 1 | Qualifies op_sel for the flag update |
| op_sel | input | 3 | Operation code (0 ADD … 7 pass) |
| inv_borrow | input | 1 | 0: direct carry/borrow flag; 1: inverted subtract sense |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| result | output | 8 | Combinational 8-bit result |
| carry_flag | output | 1 | Registered processor carry flag |

## Verification
The hardest cases to reach are the ones where the two slices carry out different operations. One example is an increment whose lower nibble wraps, so the upper slice switches from passing a to adding one. Another is a borrow-chained subtract in the inverted convention, which needs a particular stored flag before the operation starts.

The stimulus produces these cases deliberately:
- Before each binary operation, an INC of 0xFF or 0x00 forces the flag to the wanted value.
- Operands come from a boundary set around the nibble and byte edges, including 0x0F, 0x10, 0x7F, 0x80 and 0xFF.
- Increment, decrement and doubling are swept over all 256 operands in both conventions.
- ADD/ADC and SUB/SBB pairs then check that the chained 16-bit results agree with integer arithmetic.

// File: rtl/alu8_cascade.sv
module alu8_cascade #(
  parameter int NIB = 4,
  parameter int SLICES = 2,
  localparam int W = NIB * SLICES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_sel,
  input  logic         inv_borrow,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         carry_flag
);

  localparam logic [2:0] OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
                         OP_INC = 3'd4, OP_DEC = 3'd5, OP_DBL = 3'd6, OP_PASS = 3'd7;

  logic          logic_mode;
  logic [3:0]    fsel;
  logic          cin0_n;
  logic          add_like;
  logic          sub_like;
  logic [SLICES:0] cy_n;
  logic          flag_next;

  // op code -> slice controls (carry lines are active low)
  always_comb begin
    logic_mode = 1'b0;
    fsel       = 4'b1001;
    cin0_n     = 1'b1;
    add_like   = 1'b0;
    sub_like   = 1'b0;
    unique case (op_sel)
      OP_ADD: begin fsel = 4'b1001; cin0_n = 1'b1;        add_like = 1'b1; end
      OP_ADC: begin fsel = 4'b1001; cin0_n = ~carry_flag; add_like = 1'b1; end
      OP_SUB: begin fsel = 4'b0110; cin0_n = 1'b0;        sub_like = 1'b1; end
      OP_SBB: begin
        fsel     = 4'b0110;
        cin0_n   = inv_borrow ? ~carry_flag : carry_flag;
        sub_like = 1'b1;
      end
      OP_INC: begin fsel = 4'b0000; cin0_n = 1'b0;        add_like = 1'b1; end
      OP_DEC: begin fsel = 4'b1111; cin0_n = 1'b1;        sub_like = 1'b1; end
      OP_DBL: begin fsel = 4'b1100; cin0_n = 1'b1;        add_like = 1'b1; end
      default: begin logic_mode = 1'b1; fsel = 4'b1111; cin0_n = 1'b1; end
    endcase
  end

  assign cy_n[0] = cin0_n;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    logic [NIB-1:0] an, bn, t_or, t_and;
    logic [NIB:0]   sum;
    assign an    = a[g*NIB +: NIB];
    assign bn    = b[g*NIB +: NIB];
    assign t_or  = an | (bn & {NIB{fsel[0]}}) | (~bn & {NIB{fsel[1]}});
    assign t_and = (an & ~bn & {NIB{fsel[2]}}) | (an & bn & {NIB{fsel[3]}});
    assign sum   = {1'b0, t_or} + {1'b0, t_and} + {{NIB{1'b0}}, ~cy_n[g]};
    assign result[g*NIB +: NIB] = logic_mode ? ~(t_or ^ t_and) : sum[NIB-1:0];
    assign cy_n[g+1] = logic_mode | ~sum[NIB];
  end

  // per-operation decode of the final slice carry output
  always_comb begin
    flag_next = carry_flag;
    if (add_like)      flag_next = ~cy_n[SLICES];
    else if (sub_like) flag_next = inv_borrow ? ~cy_n[SLICES] : cy_n[SLICES];
  end

  always_ff @(posedge clk) begin
    if (rst)                                   carry_flag <= 1'b0;
    else if (op_valid && (add_like || sub_like)) carry_flag <= flag_next;
  end

  p_reset_clears_r9: assert property (@(posedge clk) rst |=> !carry_flag);

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel == OP_PASS) |=> $stable(carry_flag));

  p_add_sum_r1: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD) |-> (result == W'(a + b)));

  p_inc_value_r5: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INC) |-> (result == W'(a + 1'b1)));

  p_inc_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_INC) |=> (carry_flag == ($past(a) == {W{1'b1}})));

  p_dec_value_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_DEC) |-> (result == W'(a - 1'b1)));

  p_sub_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SUB) |=>
      (carry_flag == ($past(inv_borrow) ? ($past(a) >= $past(b)) : ($past(a) < $past(b)))));

  p_pass_value_r8: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_PASS) |-> (result == a));

endmodule

// File: tb/alu8_cascade_tb_top.sv
`timescale 1ns/1ps
module alu8_cascade_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd7;
  logic       inv_borrow = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] result;
  logic       carry_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mf = 0;

  typedef struct { int r; bit f; bit chk_r; int req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  alu8_cascade dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .inv_borrow(inv_borrow),
    .a(a), .b(b), .result(result), .carry_flag(carry_flag)
  );

  function automatic int req_of(input logic [2:0] op);
    return (op == 3'd7) ? 8 : int'(op) + 1;
  endfunction

  // R1..R8 reference model on plain integers
  function automatic void model(input logic [2:0] op, input bit cv, input int av, input int bv,
                                input bit f, output int r, output bit nf);
    int s;
    s = 0; nf = f;
    case (op)
      3'd0: begin s = av + bv;     nf = s > 255; end            // R1
      3'd1: begin s = av + bv + f; nf = s > 255; end            // R2
      3'd2: begin s = av - bv;     nf = cv ? (s >= 0) : (s < 0); end  // R3
      3'd3: begin s = cv ? av - bv - 1 + f : av - bv - f;       // R4
                  nf = cv ? (s >= 0) : (s < 0); end
      3'd4: begin s = av + 1;      nf = s > 255; end            // R5
      3'd5: begin s = av - 1;      nf = cv ? (s >= 0) : (s < 0); end  // R6
      3'd6: begin s = 2 * av;      nf = s > 255; end            // R7
      default: begin s = av;       nf = f; end                  // R8
    endcase
    r = s & 255;
  endfunction

  task automatic step(input bit v, input logic [2:0] op, input bit cv, input int av,
                      input int bv, input bit rs = 0, input int tag = 0);
    item_t it;
    int r; bit nf;
    model(op, cv, av, bv, mf, r, nf);
    it.r = r; it.chk_r = 1; it.req = (tag != 0) ? tag : req_of(op);
    if (rs) begin nf = 0; it.req = 9; end                 // R9
    else if (!v) begin nf = mf; it.req = 8; end           // R8
    it.f = nf;
    @(negedge clk);
    rst = rs; op_valid = v; op_sel = op; inv_borrow = cv;
    a = 8'(av); b = 8'(bv);
    q.push_back(it);
    mf = nf;
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk); #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        if (it.chk_r) begin
          checks++;
          if (int'(result) != it.r) begin
            errors++;
            $display("FAIL R%0d result op=%0d conv=%0d a=%0d b=%0d actual=%0d expected=%0d",
                     it.req, op_sel, inv_borrow, a, b, result, it.r);
          end
        end
        @(posedge clk); #1;
        checks++;
        if (carry_flag != it.f) begin
          errors++;
          $display("FAIL R%0d flag op=%0d conv=%0d actual=%0d expected=%0d",
                   it.req, op_sel, inv_borrow, carry_flag, it.f);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bnd[8] = '{0, 1, 15, 16, 127, 128, 254, 255};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #2; checks++;                                     // R9 reset state
    if (carry_flag !== 1'b0) begin
      errors++; $display("FAIL R9 reset flag actual=%0d expected=0", carry_flag);
    end
    mf = 0;

    // binary ops at boundaries, both conventions, both flag values (R1 R2 R3 R4)
    for (int cv = 0; cv < 2; cv++)
      for (int f = 0; f < 2; f++)
        for (int op = 0; op < 4; op++)
          for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
              step(1, 3'd4, cv[0], f ? 255 : 0, 0);   // R5 presets the flag
              step(1, 3'(op), cv[0], bnd[i], bnd[j]);
            end

    // unary sweeps: INC R5, DEC R6, DBL R7, pass R8
    for (int cv = 0; cv < 2; cv++)
      for (int op = 4; op < 8; op++)
        for (int av = 0; av < 256; av++)
          step(1, 3'(op), cv[0], av, av ^ 8'h5A);

    // idle op_valid low keeps the flag (R8), mid-run reset (R9)
    step(1, 3'd4, 0, 255, 0);
    step(0, 3'd0, 0, 0, 0);
    step(0, 3'd5, 1, 0, 0);
    step(1, 3'd0, 0, 200, 100, 1);

    // 16-bit chains through the stored flag (R10)
    for (int k = 0; k < 200; k++) begin
      int x, y, cv;
      x = $urandom_range(0, 65535); y = $urandom_range(0, 65535); cv = k % 2;
      step(1, 3'd0, cv[0], x & 255, y & 255, 0, 10);
      step(1, 3'd1, cv[0], x >> 8, y >> 8, 0, 10);
      step(1, 3'd2, cv[0], x & 255, y & 255, 0, 10);
      step(1, 3'd3, cv[0], x >> 8, y >> 8, 0, 10);
    end

    // random mix
    for (int k = 0; k < 20000; k++)
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 499) == 0);

    repeat (4) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule